// File: doc/BRIEF.md
# Grouped Interrupt Pending Controller

This block gathers sixteen single-cycle event strobes coming from four timer subsystems, four strobes per subsystem (sources A, B, C and D). Each strobe sets its own sticky pending flag, and each source also has its own enable bit. For each subsystem the block drives one interrupt request line. The line is high while any of that subsystem's four sources is both pending and enabled.

Software reaches the block through a simple word-wide register port. Selector 0 is the enable register and selector 1 is the pending register. Writing the pending register uses write-one-to-clear: each 1 clears a flag and each 0 leaves it alone. A subsystem can be placed in low-power mode through its sleep input. While a subsystem sleeps, its pending flags cannot be cleared, but its enable bits can still be written. Both registers can be read at any time.

Top module: `tmr_irq_pend_ctrl`

## Requirements
- R1: While reset is asserted, every pending flag and every enable bit is 0 and all four request lines are low.
- R2: Bit layout in both registers: subsystem n uses bits [4n+3:4n], with source A in bit 4n and source D in bit 4n+3. A strobe on evt_i bit k sets pending bit k at the next rising clock edge, whether or not that source is enabled.
- R3: A pending flag stays set until a software clear removes it.
- R4: A write to the pending register (wr_en_i=1, wr_sel_i=1) clears every pending bit whose data bit is 1. Bits written with 0 keep their value.
- R5: If a strobe and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R6: While sleep_i[n]=1, writes to the pending register leave subsystem n's four pending bits unchanged. Other subsystems still clear normally.
- R7: A write to the enable register (wr_en_i=1, wr_sel_i=0) loads all sixteen enable bits at the next edge, including the bits of sleeping subsystems.
- R8: irq_o[n] is high exactly when at least one of subsystem n's sources is both pending and enabled. It follows the register state with no extra cycle of delay.
- R9: rd_data_o shows the enable register when rd_sel_i=0 and the pending register when rd_sel_i=1. It responds combinationally at any time, sleep included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 16 | Event strobes, subsystem n in bits [4n+3:4n] |
| sleep_i | input | 4 | Low-power mode, one bit per subsystem |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 enable, 1 pending |
| wr_data_i | input | 16 | Write data |
| rd_sel_i | input | 1 | Read target: 0 enable, 1 pending |
| rd_data_o | output | 16 | Read data |
| irq_o | output | 4 | Interrupt request per subsystem |

## Verification
The first directed patterns raise strobes while all enables are 0. Here the pending register must change but the request lines must stay low, which separates flag setting from request generation. Later patterns clear with an alternating 1/0 mask, and with a strobe and a clear landing on the same bit in the same cycle. These expose a clear applied to the wrong bits, and a clear that wins over a set. A sleep phase holds one subsystem while the others clear, and rewrites that subsystem's enables, so blocked clears can be told apart from blocked enable writes. A long pseudo-random phase then mixes strobes, writes, sleep and read selects, and compares every request line and read value against the bench's model on every clock.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    localparam int GRP_N = 4;
    localparam int SRC_N = 4;
    localparam int VEC_W = GRP_N * SRC_N;

    typedef enum logic {
        SEL_ENABLE  = 1'b0,
        SEL_PENDING = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/tmr_irq_group.sv
module tmr_irq_group #(
    parameter int SRC_N = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] evt_i,
    input  logic             sleep_i,
    input  logic [SRC_N-1:0] clr_i,
    input  logic             en_we_i,
    input  logic [SRC_N-1:0] en_d_i,
    output logic [SRC_N-1:0] pend_o,
    output logic [SRC_N-1:0] en_o,
    output logic             irq_o
);
    logic [SRC_N-1:0] pend_q, pend_d, en_q;
    logic [SRC_N-1:0] clr_eff;

    // low power blocks every clear of this group
    assign clr_eff = sleep_i ? '0 : clr_i;

    always_comb begin
        pend_d = (pend_q & ~clr_eff) | evt_i;  // set has priority
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
        end else begin
            pend_q <= pend_d;
            if (en_we_i) en_q <= en_d_i;
        end
    end

    assign pend_o = pend_q;
    assign en_o   = en_q;
    assign irq_o  = |(pend_q & en_q);
endmodule

// File: rtl/tmr_irq_readback.sv
module tmr_irq_readback #(
    parameter int VEC_W = 16
) (
    input  tmr_irq_pkg::reg_sel_e sel_i,
    input  logic [VEC_W-1:0]      pend_i,
    input  logic [VEC_W-1:0]      en_i,
    output logic [VEC_W-1:0]      data_o
);
    always_comb begin
        unique case (sel_i)
            tmr_irq_pkg::SEL_ENABLE:  data_o = en_i;
            tmr_irq_pkg::SEL_PENDING: data_o = pend_i;
            default:                  data_o = '0;
        endcase
    end
endmodule

// File: rtl/tmr_irq_pend_ctrl.sv
module tmr_irq_pend_ctrl
    import tmr_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VEC_W-1:0] evt_i,
    input  logic [GRP_N-1:0] sleep_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [VEC_W-1:0] wr_data_i,
    input  logic             rd_sel_i,
    output logic [VEC_W-1:0] rd_data_o,
    output logic [GRP_N-1:0] irq_o
);
    logic [VEC_W-1:0] pend_all, en_all, clr_req;
    logic             en_we;
    reg_sel_e         wsel, rsel;

    assign wsel    = reg_sel_e'(wr_sel_i);
    assign rsel    = reg_sel_e'(rd_sel_i);
    assign clr_req = (wr_en_i && wsel == SEL_PENDING) ? wr_data_i : '0;
    assign en_we   = wr_en_i && (wsel == SEL_ENABLE);

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        tmr_irq_group #(.SRC_N(SRC_N)) grp_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt_i[g*SRC_N +: SRC_N]),
            .sleep_i (sleep_i[g]),
            .clr_i   (clr_req[g*SRC_N +: SRC_N]),
            .en_we_i (en_we),
            .en_d_i  (wr_data_i[g*SRC_N +: SRC_N]),
            .pend_o  (pend_all[g*SRC_N +: SRC_N]),
            .en_o    (en_all[g*SRC_N +: SRC_N]),
            .irq_o   (irq_o[g])
        );
    end

    tmr_irq_readback #(.VEC_W(VEC_W)) rb_i (
        .sel_i  (rsel),
        .pend_i (pend_all),
        .en_i   (en_all),
        .data_o (rd_data_o)
    );
endmodule

// File: rtl/tmr_irq_pend_chk.sv
module tmr_irq_pend_chk
    import tmr_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [VEC_W-1:0] evt_i,
    input logic [GRP_N-1:0] sleep_i,
    input logic             wr_en_i,
    input logic             wr_sel_i,
    input logic [VEC_W-1:0] wr_data_i,
    input logic [VEC_W-1:0] pend_all,
    input logic [VEC_W-1:0] en_all,
    input logic [GRP_N-1:0] irq_o
);
    logic [VEC_W-1:0] smask;
    always_comb begin
        for (int i = 0; i < VEC_W; i++) smask[i] = sleep_i[i / SRC_N];
    end

    always @(posedge clk) begin
        if (rst_n === 1'b0)
            assert_reset_clear_R1: assert (pend_all == '0 && en_all == '0 && irq_o == '0);
    end

    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_all & $past(evt_i)) == $past(evt_i)));

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_sel_i) |=> (($past(pend_all) & ~pend_all) == '0));

    assert_sleep_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pend_all) & $past(smask)) & ~pend_all) == '0));

    assert_en_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !wr_sel_i) |=> (en_all == $past(wr_data_i)));

    assert_no_irq_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_all == '0) |-> (irq_o == '0));
endmodule

bind tmr_irq_pend_ctrl tmr_irq_pend_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .sleep_i   (sleep_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .pend_all  (pend_all),
    .en_all    (en_all),
    .irq_o     (irq_o)
);

// File: tb/tmr_irq_pend_ctrl_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_pend_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt = '0;
    logic [3:0]  sleep = '0;
    logic        we = 1'b0, wsel = 1'b0, rsel = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [3:0]  irq;

    int checks = 0, errors = 0;
    bit done = 0;
    bit m_pend [16];
    bit m_en [16];
    string tag = "R1";

    always #5 clk = ~clk;

    tmr_irq_pend_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .sleep_i(sleep),
        .wr_en_i(we), .wr_sel_i(wsel), .wr_data_i(wdata),
        .rd_sel_i(rsel), .rd_data_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rd();
        logic [15:0] v;
        for (int i = 0; i < 16; i++) v[i] = rsel ? m_pend[i] : m_en[i];
        return v;
    endfunction

    function automatic logic [15:0] exp_irq();
        logic [15:0] v = '0;
        for (int i = 0; i < 16; i++) if (m_pend[i] && m_en[i]) v[i / 4] = 1'b1;
        return v;
    endfunction

    task automatic compare();
        check({tag, " R8 irq"}, {12'h0, irq}, exp_irq());
        check({tag, " R9 read"}, rdata, exp_rd());
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic cyc(input logic [15:0] e, input logic [3:0] s, input logic w,
                       input logic ws, input logic [15:0] d, input logic rs);
        evt = e; sleep = s; we = w; wsel = ws; wdata = d; rsel = rs;
        @(posedge clk);
        for (int i = 0; i < 16; i++) begin
            if (e[i]) m_pend[i] = 1;
            else if (w && ws && d[i] && !s[i / 4]) m_pend[i] = 0;
        end
        if (w && !ws) for (int i = 0; i < 16; i++) m_en[i] = d[i];
        @(negedge clk);
        compare();
    endtask

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < 16; i++) begin m_pend[i] = 0; m_en[i] = 0; end
        repeat (3) @(negedge clk);
        tag = "R1"; rsel = 1'b1; #1 compare();
        rsel = 1'b0; #1 compare();
        rst_n = 1'b1;
        @(negedge clk);
        tag = "R2"; cyc(16'h8421, 4'h0, 0, 0, 16'h0, 1);
        cyc(16'h0000, 4'h0, 0, 0, 16'h0, 1);
        tag = "R3"; repeat (3) cyc(16'h0, 4'h0, 0, 0, 16'h0, 1);
        tag = "R7"; cyc(16'h0, 4'h0, 1, 0, 16'h0F01, 0);
        tag = "R8"; cyc(16'h0, 4'h0, 0, 0, 16'h0, 0);
        cyc(16'hFFFF, 4'h0, 0, 0, 16'h0, 1);
        tag = "R4"; cyc(16'h0, 4'h0, 1, 1, 16'hA5A5, 1);
        cyc(16'h0, 4'h0, 1, 1, 16'h0000, 1);
        tag = "R5"; cyc(16'h0010, 4'h0, 1, 1, 16'hFFFF, 1);
        cyc(16'hFFFF, 4'h0, 0, 0, 16'h0, 1);
        tag = "R6"; cyc(16'h0, 4'h4, 1, 1, 16'hFFFF, 1);
        tag = "R7"; cyc(16'h0, 4'h4, 1, 0, 16'h0F00, 0);
        tag = "R9"; cyc(16'h0, 4'h4, 0, 0, 16'h0, 1);
        tag = "R6"; cyc(16'h0, 4'h0, 1, 1, 16'hFFFF, 1);
        tag = "R2"; cyc(16'h0200, 4'h0, 0, 0, 16'h0, 1);
        tag = "R8";
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr & {lfsr[7:0], lfsr[15:8]} & 16'h1248, lfsr[11:8],
                lfsr[3], lfsr[5], {lfsr[6:0], lfsr[15:7]}, lfsr[9]);
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule